// File: doc/BRIEF.md
# Correctable-Error Write-Back Scheduler

This block sits beside the ECC decoder on the read-return path of a memory controller. Each returning read carries a correctable flag, an uncorrectable flag and its address. When a normal read shows a correctable single-bit error, and both the ECC enable and the write-back enable are set, the address goes into a small queue of pending scrubs. Double-bit errors are never queued. An address that is already waiting is not queued a second time. A full queue drops the new request and sets a sticky overflow flag.

The scheduler handles one queued address at a time. It first sends a fresh read of that location to the command arbiter. It does not write back the data that came with the failing read, because a write may have reached the location since then, and the fresh read keeps that write. When the tagged scrub read returns with a correctable error, the scheduler sends a write of the corrected data, and the write path generates new check bits. When the scrub read returns clean or uncorrectable, no write is sent. In every case the entry then leaves the queue. Commands use a valid/ready handshake, and the arbiter applies its own priority against normal traffic.

Top module: `ecc_scrub_sched`

## Requirements
- R1: After reset, `cmdValid` and `overflow` are 0 and no scrub is pending.
- R2: A normal read return (`rdIsScrub`=0) with `rdCorrectable`=1 and `rdUncorrectable`=0, while `eccEnable`=1 and `writeBackEn`=1, queues its `rdAddr` for a scrub. A return with neither flag set queues nothing.
- R3: While `eccEnable`=0 or `writeBackEn`=0, no read return queues a scrub.
- R4: A return with `rdUncorrectable`=1 never queues a scrub, even when `rdCorrectable` is also 1.
- R5: Each scrub begins with a read command (`cmdWrite`=0) to the queued address. A write for that scrub is issued only after a return tagged `rdIsScrub`=1 has arrived.
- R6: If the scrub read returns `rdCorrectable`=1 and `rdUncorrectable`=0, a write command (`cmdWrite`=1) follows to the same address. Its `cmdData` is the data of that scrub return, not the data of the original failing read.
- R7: If the scrub read returns uncorrectable, or with no error, no write is issued and the entry is retired.
- R8: A qualifying error whose address equals an entry still pending, including the one being scrubbed, is not queued again.
- R9: With DEPTH (default 4) entries pending, a further distinct qualifying error is dropped and `overflow` goes to 1. It stays at 1 until reset.
- R10: Queued addresses are scrubbed in arrival order.
- R11: While `cmdValid`=1 and `cmdReady`=0, `cmdValid`, `cmdWrite`, `cmdAddr` and `cmdData` hold their values.
- R12: Returns tagged `rdIsScrub`=1 never queue a scrub.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eccEnable | input | 1 | ECC checking enabled |
| writeBackEn | input | 1 | Configuration enable for correctable-error write-back |
| rdValid | input | 1 | Read return valid |
| rdIsScrub | input | 1 | Return belongs to this block's own scrub read |
| rdCorrectable | input | 1 | Decoder found a correctable error |
| rdUncorrectable | input | 1 | Decoder found an uncorrectable error |
| rdAddr | input | ADDR_W | Address of the returning read |
| rdData | input | DATA_W | Corrected read data |
| cmdReady | input | 1 | Arbiter accepts the current command |
| cmdValid | output | 1 | Scrub command present |
| cmdWrite | output | 1 | 1 = write of corrected data, 0 = scrub read |
| cmdAddr | output | ADDR_W | Scrub command address |
| cmdData | output | DATA_W | Write data for scrub writes |
| overflow | output | 1 | Sticky: a scrub request was dropped on a full queue |

## Verification
A bad queue pointer or valid bit shows up at the ports within a few cycles of the next command. The bench then sees a scrub issued to the wrong address, out of order, repeated, or missing after a run of errors. A wrong sequencer state shows up on the first scrub as a write with no read before it, a write after a clean or uncorrectable scrub return, or write data taken from the original read. Count and overflow errors show up when the queue fills: either the drop fails to appear, or the flag is set too early. Either way the fault is visible before the queue has drained.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef struct packed {
    logic push;     // enqueue the incoming address
    logic drop;     // qualifying request lost to a full queue
    logic pop;      // retire the head entry
    logic capture;  // latch scrub-return data for the write
  } qStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND_RD,
    ST_WAIT_RD,
    ST_SEND_WR
  } scrubState_t;
endpackage

// File: rtl/scrub_wb_store.sv
module scrub_wb_store
  import scrub_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strb,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] heldData,
  output logic              empty,
  output logic              full,
  output logic              hit,
  output logic [$clog2(DEPTH+1)-1:0] occupancy,
  output logic              overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] slotAddr [DEPTH];
  logic [DEPTH-1:0]  slotValid;
  logic [DEPTH-1:0]  slotMatch;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    assign slotMatch[g] = slotValid[g] && (slotAddr[g] == inAddr);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[g] <= 1'b0;
        slotAddr[g]  <= '0;
      end else if (strb.push && wrPtr == PTR_W'(g)) begin
        slotValid[g] <= 1'b1;
        slotAddr[g]  <= inAddr;
      end else if (strb.pop && rdPtr == PTR_W'(g)) begin
        slotValid[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
      heldData <= '0;
    end else begin
      if (strb.push) wrPtr <= stepPtr(wrPtr);
      if (strb.pop)  rdPtr <= stepPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (strb.drop)    overflow <= 1'b1;
      if (strb.capture) heldData <= inData;
    end
  end

  assign hit       = |slotMatch;
  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign headAddr  = slotAddr[rdPtr];
  assign occupancy = count;
endmodule

// File: rtl/scrub_wb_ctrl.sv
module scrub_wb_ctrl
  import scrub_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     eccEnable,
  input  logic     writeBackEn,
  input  logic     rdValid,
  input  logic     rdIsScrub,
  input  logic     rdCorrectable,
  input  logic     rdUncorrectable,
  input  logic     cmdReady,
  input  logic     empty,
  input  logic     full,
  input  logic     hit,
  output qStrobe_t strb,
  output logic     cmdValid,
  output logic     cmdWrite
);
  scrubState_t state, stateNext;
  logic wantScrub, scrubReturn, fixable;

  // Only normal returns with a single-bit error and both enables qualify.
  assign wantScrub = rdValid && !rdIsScrub && rdCorrectable && !rdUncorrectable
                     && eccEnable && writeBackEn;
  assign scrubReturn = rdValid && rdIsScrub && (state == ST_WAIT_RD);
  assign fixable     = rdCorrectable && !rdUncorrectable;

  always_comb begin
    stateNext    = state;
    strb         = '0;
    strb.push    = wantScrub && !hit && !full;
    strb.drop    = wantScrub && !hit && full;
    unique case (state)
      ST_IDLE:    if (!empty) stateNext = ST_SEND_RD;
      ST_SEND_RD: if (cmdReady) stateNext = ST_WAIT_RD;
      ST_WAIT_RD: if (scrubReturn) begin
                    if (fixable) begin
                      strb.capture = 1'b1;
                      stateNext    = ST_SEND_WR;
                    end else begin
                      strb.pop  = 1'b1;
                      stateNext = ST_IDLE;
                    end
                  end
      ST_SEND_WR: if (cmdReady) begin
                    strb.pop  = 1'b1;
                    stateNext = ST_IDLE;
                  end
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cmdValid = (state == ST_SEND_RD) || (state == ST_SEND_WR);
  assign cmdWrite = (state == ST_SEND_WR);
endmodule

// File: rtl/ecc_scrub_sched.sv
module ecc_scrub_sched
  import scrub_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eccEnable,
  input  logic              writeBackEn,
  input  logic              rdValid,
  input  logic              rdIsScrub,
  input  logic              rdCorrectable,
  input  logic              rdUncorrectable,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic              cmdReady,
  output logic              cmdValid,
  output logic              cmdWrite,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic              overflow
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  qStrobe_t         strb;
  logic             qEmpty, qFull, qHit;
  logic [CNT_W-1:0] occupancy;

  scrub_wb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .eccEnable(eccEnable), .writeBackEn(writeBackEn),
    .rdValid(rdValid), .rdIsScrub(rdIsScrub),
    .rdCorrectable(rdCorrectable), .rdUncorrectable(rdUncorrectable),
    .cmdReady(cmdReady),
    .empty(qEmpty), .full(qFull), .hit(qHit),
    .strb(strb), .cmdValid(cmdValid), .cmdWrite(cmdWrite)
  );

  scrub_wb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inAddr(rdAddr), .inData(rdData),
    .headAddr(cmdAddr), .heldData(cmdData),
    .empty(qEmpty), .full(qFull), .hit(qHit),
    .occupancy(occupancy), .overflow(overflow)
  );
endmodule

// File: rtl/ecc_scrub_sched_chk.sv
module ecc_scrub_sched_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              eccEnable,
  input logic              writeBackEn,
  input logic              rdValid,
  input logic              rdIsScrub,
  input logic              rdUncorrectable,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic              cmdWrite,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [DATA_W-1:0] cmdData,
  input logic              overflow,
  input logic [$clog2(DEPTH+1)-1:0] occupancy
);
  assert_disabled_no_grow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!rdValid || !eccEnable || !writeBackEn) |=> occupancy <= $past(occupancy));

  assert_double_no_grow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdUncorrectable) |=> occupancy <= $past(occupancy));

  assert_scrub_tag_no_grow_R12: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdIsScrub) |=> occupancy <= $past(occupancy));

  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> cmdValid && $stable(cmdWrite)
                                && $stable(cmdAddr) && $stable(cmdData));

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_occupancy_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= ($clog2(DEPTH+1))'(DEPTH));

  assert_cmd_needs_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> occupancy != '0);
endmodule

bind ecc_scrub_sched ecc_scrub_sched_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) chk (
  .clk(clk), .rstN(rstN), .eccEnable(eccEnable), .writeBackEn(writeBackEn),
  .rdValid(rdValid), .rdIsScrub(rdIsScrub), .rdUncorrectable(rdUncorrectable),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWrite(cmdWrite),
  .cmdAddr(cmdAddr), .cmdData(cmdData), .overflow(overflow),
  .occupancy(occupancy)
);

// File: tb/tb_ecc_scrub_sched.sv
module tb_ecc_scrub_sched;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eccEnable = 1'b1, writeBackEn = 1'b1;
  logic rdValid = 1'b0, rdIsScrub = 1'b0, rdCorrectable = 1'b0, rdUncorrectable = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData = '0;
  logic cmdReady = 1'b0;
  logic cmdValid, cmdWrite, overflow;
  logic [ADDR_W-1:0] cmdAddr;
  logic [DATA_W-1:0] cmdData;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ecc_scrub_sched #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(4)) dut (
    .clk(clk), .rstN(rstN), .eccEnable(eccEnable), .writeBackEn(writeBackEn),
    .rdValid(rdValid), .rdIsScrub(rdIsScrub), .rdCorrectable(rdCorrectable),
    .rdUncorrectable(rdUncorrectable), .rdAddr(rdAddr), .rdData(rdData),
    .cmdReady(cmdReady), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .overflow(overflow)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic corr, unc, ecc, wb, expScrub;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'h0010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{16'h0020, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{16'h0030, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{16'h0040, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{16'h0050, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{16'h0060, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic inject(input logic [ADDR_W-1:0] a, input logic c, input logic u,
                        input logic tag, input logic [DATA_W-1:0] d);
    @(negedge clk);
    rdValid = 1'b1; rdAddr = a; rdCorrectable = c; rdUncorrectable = u;
    rdIsScrub = tag; rdData = d;
    @(negedge clk);
    rdValid = 1'b0; rdCorrectable = 1'b0; rdUncorrectable = 1'b0; rdIsScrub = 1'b0;
  endtask

  task automatic waitCmd(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 12 && !seen; i++) begin
      if (cmdValid) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic quietFor(input int n, input string req);
    bit any = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cmdValid) any = 1'b1;
    end
    check(!any, req, any, 0);
  endtask

  task automatic serviceScrub(input logic [ADDR_W-1:0] expAddr, input logic reC,
                              input logic reU, input logic [DATA_W-1:0] reData,
                              input bit expWrite);
    bit seen;
    waitCmd(seen);
    check(seen && !cmdWrite, "R5 scrub starts with read", {cmdValid, cmdWrite}, 2'b10);
    check(cmdAddr == expAddr, "R10 scrub address/order", cmdAddr, expAddr);
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
    check(!cmdValid, "R5 no write before scrub return", cmdValid, 0);
    inject(expAddr, reC, reU, 1'b1, reData);
    if (expWrite) begin
      check(cmdValid && cmdWrite, "R6 write follows correctable re-read",
            {cmdValid, cmdWrite}, 2'b11);
      check(cmdAddr == expAddr && cmdData == reData, "R6 write addr/data",
            {cmdAddr, cmdData}, {expAddr, reData});
      cmdReady = 1'b1;
      @(negedge clk);
      cmdReady = 1'b0;
    end else begin
      check(!(cmdValid && cmdWrite), "R7 no write after bad/clean re-read",
            {cmdValid, cmdWrite}, 2'b00);
      @(negedge clk);
      check(!(cmdValid && cmdWrite), "R7 no write after bad/clean re-read",
            {cmdValid, cmdWrite}, 2'b00);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit seen;
    logic [ADDR_W-1:0] held;
    repeat (3) @(negedge clk);
    check(cmdValid == 1'b0, "R1 reset cmdValid", cmdValid, 0);
    check(overflow == 1'b0, "R1 reset overflow", overflow, 0);
    rstN = 1'b1;
    quietFor(4, "R1 nothing pending after reset");

    // Table walk: R2, R3, R4
    foreach (VECS[i]) begin
      eccEnable = VECS[i].ecc; writeBackEn = VECS[i].wb;
      inject(VECS[i].addr, VECS[i].corr, VECS[i].unc, 1'b0, 32'hAAAA_0000 | 32'(i));
      eccEnable = 1'b1; writeBackEn = 1'b1;
      if (VECS[i].expScrub)
        serviceScrub(VECS[i].addr, 1'b1, 1'b0, {VECS[i].addr, ~VECS[i].addr}, 1'b1);
      else if (!VECS[i].ecc || !VECS[i].wb)
        quietFor(8, "R3 disabled gives no scrub");
      else if (VECS[i].unc)
        quietFor(8, "R4 uncorrectable gives no scrub");
      else
        quietFor(8, "R2 clean read gives no scrub");
    end

    // R12: scrub-tagged return while idle
    inject(16'h0123, 1'b1, 1'b0, 1'b1, 32'h1);
    quietFor(8, "R12 scrub-tagged return not queued");

    // R8 dedup, R7 clean re-read, R10 order
    inject(16'h0100, 1'b1, 1'b0, 1'b0, 32'h11);
    inject(16'h0100, 1'b1, 1'b0, 1'b0, 32'h12);
    inject(16'h0200, 1'b1, 1'b0, 1'b0, 32'h13);
    serviceScrub(16'h0100, 1'b1, 1'b0, 32'hCAFE_0100, 1'b1);
    serviceScrub(16'h0200, 1'b0, 1'b0, 32'h0, 1'b0);
    quietFor(10, "R8 duplicate not scrubbed twice");

    // R9 overflow, R11 hold, R10 order, R7 uncorrectable re-read
    inject(16'h0301, 1'b1, 1'b0, 1'b0, 32'h0);
    inject(16'h0302, 1'b1, 1'b0, 1'b0, 32'h0);
    inject(16'h0303, 1'b1, 1'b0, 1'b0, 32'h0);
    check(overflow == 1'b0, "R9 no overflow below full", overflow, 0);
    inject(16'h0304, 1'b1, 1'b0, 1'b0, 32'h0);
    check(overflow == 1'b0, "R9 no overflow at exactly full", overflow, 0);
    waitCmd(seen);
    held = cmdAddr;
    repeat (5) @(negedge clk);
    check(cmdValid && !cmdWrite && cmdAddr == held, "R11 command held while stalled",
          cmdAddr, held);
    inject(16'h0305, 1'b1, 1'b0, 1'b0, 32'h0);
    check(overflow == 1'b1, "R9 overflow on full queue", overflow, 1);
    for (int k = 1; k <= 4; k++)
      serviceScrub(16'h0300 + 16'(k), 1'b0, 1'b1, 32'h0, 1'b0);
    quietFor(10, "R9 dropped entry never scrubbed");
    check(overflow == 1'b1, "R9 overflow sticky", overflow, 1);

    // R1: reset clears sticky flag
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(overflow == 1'b0 && cmdValid == 1'b0, "R1 reset clears state",
          {overflow, cmdValid}, 2'b00);
    rstN = 1'b1;
    quietFor(4, "R1 quiet after second reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule